// File: doc/BRIEF.md
# Variable-Width Sum-of-Products Array

This block is the logic core of a small programmable logic device. Ten dedicated input signals and eight feedback signals each produce a true line and a complement line, 36 lines in all. One connection bit per line per product term decides which lines each term uses. A product term is the AND of all its connected lines.

The product terms fall into two groups. Most of them are OR-ed into eight sums. Each sum uses a fixed number of terms, and that number differs from output to output. The remaining terms are used directly as control signals: one output-enable per output, a global synchronous preset, a global asynchronous clear and a clock source.

The connection bits arrive as one wide configuration vector. The block is purely combinational. The surrounding macrocells, registers and pins use the sums and the control terms; they are not part of this block.

Top module: `sop_array`

## Requirements
- R1: Array lines are ordered with dedicated input k on line 2k (true) and line 2k+1 (complement), for k = 0..9. Feedback j is on line 20+2j (true) and line 21+2j (complement), for j = 0..7.
- R2: The connection bits of product term t are `cfg[36*t +: 36]`, one bit per line in line order. A bit of 1 means the line is connected. The term is the AND of every connected line.
- R3: A term whose 36 connection bits are all 0 evaluates TRUE for every input pattern. A fully zero configuration therefore drives every output high.
- R4: A term connected to both lines of one signal (true and complement) evaluates FALSE for every input pattern. A fully ones configuration therefore drives every output low.
- R5: Terms 0..101 are sum terms and are assigned to the outputs in ascending order with no gaps. Output 0 through output 7 get 8, 8, 10, 12, 14, 16, 16 and 18 terms respectively. Output 0 starts at term 0.
- R6: `sum_o[o]` is the OR of exactly the terms assigned to output o. A term with all 36 bits set contributes nothing to its sum.
- R7: Term 102+o drives `oe_o[o]` for o = 0..7.
- R8: Term 110 drives `preset_o`, term 111 drives `clear_o` and term 112 drives `clk_term_o`.
- R9: Every output follows its inputs combinationally, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | 10 | Dedicated input signals |
| fb | input | 8 | Feedback signals from the output cells |
| cfg | input | 4068 | Connection bits, 36 per product term |
| sum_o | output | 8 | One sum-of-products result per output |
| oe_o | output | 8 | Output-enable terms, one per output |
| preset_o | output | 1 | Global synchronous preset term |
| clear_o | output | 1 | Global asynchronous clear term |
| clk_term_o | output | 1 | Clock product term |

## Verification
The assertions are evaluated whenever the inputs change. They cover four conditions:
- a fully open preset term must read TRUE;
- an enable term that holds a true/complement pair must read FALSE;
- a sum whose terms are all fully closed must read FALSE;
- any fully open term in a group must force its sum TRUE.

Some properties can only be shown by the bench's scenarios, which open single terms at both edges of every group. These are the exact line ordering, the bit positions of each term, and where each group boundary falls. A random-pattern comparison against an independent model covers mixed connections on all 113 terms.

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN  = 10,
  parameter int N_FB  = 8,
  parameter int N_OUT = 8,
  parameter int N_SUM = 102,
  parameter int GRP [N_OUT] = '{8, 8, 10, 12, 14, 16, 16, 18},
  localparam int LW   = 2 * (N_IN + N_FB),
  localparam int N_PT = N_SUM + N_OUT + 3
) (
  input  logic [N_IN-1:0]     din,
  input  logic [N_FB-1:0]     fb,
  input  logic [N_PT*LW-1:0]  cfg,
  output logic [N_OUT-1:0]    sum_o,
  output logic [N_OUT-1:0]    oe_o,
  output logic                preset_o,
  output logic                clear_o,
  output logic                clk_term_o
);

  function automatic int grp_base(input int o);
    int acc = 0;
    for (int i = 0; i < o; i++) acc += GRP[i];
    return acc;
  endfunction

  localparam int PT_OE  = N_SUM;
  localparam int PT_PRE = N_SUM + N_OUT;
  localparam int PT_CLR = PT_PRE + 1;
  localparam int PT_CLK = PT_PRE + 2;

  if (grp_base(N_OUT) != N_SUM) begin : g_bad_split
    $error("sum term split does not add up to N_SUM");
  end

  logic [LW-1:0]   lines;
  logic [N_PT-1:0] pt;

  // lines: true/complement pairs, dedicated inputs first
  for (genvar k = 0; k < N_IN; k++) begin : g_in
    assign lines[2*k]   = din[k];
    assign lines[2*k+1] = ~din[k];
  end
  for (genvar j = 0; j < N_FB; j++) begin : g_fb
    assign lines[2*N_IN+2*j]   = fb[j];
    assign lines[2*N_IN+2*j+1] = ~fb[j];
  end

  // an open connection (0) forces its input of the AND high
  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    assign pt[t] = &(lines | ~cfg[t*LW +: LW]);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    localparam int BASE = grp_base(o);
    assign sum_o[o] = |pt[BASE +: GRP[o]];
  end

  assign oe_o       = pt[PT_OE +: N_OUT];
  assign preset_o   = pt[PT_PRE];
  assign clear_o    = pt[PT_CLR];
  assign clk_term_o = pt[PT_CLK];

  always_comb begin
    if (cfg[PT_PRE*LW +: LW] == '0)
      AST_OPEN_TERM_TRUE: assert (preset_o); // R3
  end

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      logic [LW-1:0] c;
      logic contra;
      c = cfg[(PT_OE+o)*LW +: LW];
      contra = 1'b0;
      for (int k = 0; k < LW/2; k++) contra |= c[2*k] & c[2*k+1];
      if (contra)
        AST_CONTRA_TERM_FALSE: assert (!oe_o[o]); // R4
    end
  end

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      logic all_closed;
      logic any_open;
      all_closed = 1'b1;
      any_open   = 1'b0;
      for (int i = 0; i < GRP[o]; i++) begin
        all_closed &= &cfg[(grp_base(o)+i)*LW +: LW];
        any_open   |= (cfg[(grp_base(o)+i)*LW +: LW] == '0);
      end
      if (all_closed)
        AST_CLOSED_GROUP_LOW: assert (!sum_o[o]); // R6
      if (any_open)
        AST_OPEN_MEMBER_HIGH: assert (sum_o[o]); // R5
    end
  end

endmodule

// File: tb/sop_array_tb.sv
module sop_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 36;
  localparam int NPT = 113;
  localparam int CW = NPT * LW;
  localparam int GRP [8] = '{8, 8, 10, 12, 14, 16, 16, 18};

  typedef struct packed {
    logic [35:0] conn;
    logic [9:0]  d;
    logic [7:0]  f;
    logic        exp;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{36'h0,           10'h000, 8'h00, 1'b1},
    '{36'h0,           10'h3FF, 8'hFF, 1'b1},
    '{36'h1,           10'h001, 8'h00, 1'b1},
    '{36'h1,           10'h000, 8'h00, 1'b0},
    '{36'h2,           10'h000, 8'h00, 1'b1},
    '{36'h3,           10'h001, 8'h00, 1'b0},
    '{36'h3,           10'h000, 8'h00, 1'b0},
    '{36'h0_0010_0000, 10'h000, 8'h01, 1'b1},
    '{36'h0_0010_0000, 10'h3FF, 8'hFE, 1'b0},
    '{36'h8_0000_0000, 10'h000, 8'h80, 1'b0},
    '{36'h8_0000_0000, 10'h000, 8'h7F, 1'b1},
    '{36'h0_0004_0000, 10'h200, 8'h00, 1'b1},
    '{36'h0_0005_5555, 10'h3FF, 8'h00, 1'b1},
    '{36'h0_0005_5555, 10'h3FE, 8'h00, 1'b0}
  };

  logic clk = 1'b0;
  logic [9:0]    din;
  logic [7:0]    fb;
  logic [CW-1:0] cfg;
  logic [7:0]    sum_o, oe_o;
  logic          preset_o, clear_o, clk_term_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_array u_dut (
    .din(din), .fb(fb), .cfg(cfg), .sum_o(sum_o), .oe_o(oe_o),
    .preset_o(preset_o), .clear_o(clear_o), .clk_term_o(clk_term_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic model_term(input logic [35:0] c, input logic [9:0] d, input logic [7:0] f);
    for (int i = 0; i < 36; i++) begin
      logic v;
      if (i < 20) v = (i % 2 == 0) ? d[i/2] : !d[i/2];
      else        v = (i % 2 == 0) ? f[(i-20)/2] : !f[(i-20)/2];
      if (c[i] && !v) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic int base_of(input int o);
    int b = 0;
    for (int i = 0; i < o; i++) b += GRP[i];
    return b;
  endfunction

  task automatic settle;
    #(CLK_PERIOD/2);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    #2;
    // erased configuration: all open, every output high (R3, R9)
    din = '0; fb = '0; cfg = '0;
    settle();
    chk("R3 erased sums", sum_o, 8'hFF);
    chk("R3 erased oe", oe_o, 8'hFF);
    chk("R3 erased specials", {5'b0, preset_o, clear_o, clk_term_o}, 8'h07);
    // fully closed: contradictions everywhere (R4)
    cfg = '1;
    settle();
    chk("R4 closed sums", sum_o, 8'h00);
    chk("R4 closed oe", oe_o, 8'h00);
    chk("R4 closed specials", {5'b0, preset_o, clear_o, clk_term_o}, 8'h00);

    // table walk: single-term patterns on preset (110) and clock (112) terms (R1, R2, R8)
    foreach (VEC[n]) begin
      cfg = '1;
      cfg[110*LW +: LW] = VEC[n].conn;
      cfg[112*LW +: LW] = VEC[n].conn;
      din = VEC[n].d; fb = VEC[n].f;
      settle();
      chk("R1 R2 preset term", {7'b0, preset_o}, {7'b0, VEC[n].exp});
      chk("R8 clock term", {7'b0, clk_term_o}, {7'b0, VEC[n].exp});
      chk("R8 clear untouched", {7'b0, clear_o}, 8'h00);
      settle();
    end

    // clear term 111 alone (R8)
    cfg = '1; cfg[111*LW +: LW] = '0; din = '0; fb = '0;
    settle();
    chk("R8 clear term", {6'b0, preset_o, clear_o}, 8'h01);

    // group boundaries: open first and last term of each group (R5, R6)
    for (int o = 0; o < 8; o++) begin
      cfg = '1; cfg[base_of(o)*LW +: LW] = '0;
      settle();
      chk("R5 first term of group", sum_o, 8'h01 << o);
      cfg = '1; cfg[(base_of(o)+GRP[o]-1)*LW +: LW] = '0;
      settle();
      chk("R5 last term of group", sum_o, 8'h01 << o);
    end

    // enable terms 102..109 (R7)
    for (int o = 0; o < 8; o++) begin
      cfg = '1; cfg[(102+o)*LW +: LW] = '0;
      settle();
      chk("R7 enable term", oe_o, 8'h01 << o);
      chk("R7 sums unaffected", sum_o, 8'h00);
    end

    // random sparse patterns against an independent model (R2, R6, R9)
    for (int it = 0; it < 60; it++) begin
      logic [NPT-1:0] t_exp;
      logic [7:0] s_exp;
      for (int t = 0; t < NPT; t++) begin
        logic [35:0] c;
        c = '0;
        if ($urandom_range(3) != 0) begin
          int nc;
          nc = $urandom_range(1, 3);
          for (int q = 0; q < nc; q++) c[$urandom_range(35)] = 1'b1;
        end
        cfg[t*LW +: LW] = c;
      end
      din = 10'($urandom); fb = 8'($urandom);
      for (int t = 0; t < NPT; t++) t_exp[t] = model_term(cfg[t*LW +: LW], din, fb);
      for (int o = 0; o < 8; o++) begin
        s_exp[o] = 1'b0;
        for (int i = 0; i < GRP[o]; i++) s_exp[o] |= t_exp[base_of(o)+i];
      end
      settle();
      chk("R6 random sums", sum_o, s_exp);
      chk("R7 random oe", oe_o, t_exp[102 +: 8]);
      chk("R8 random specials", {5'b0, preset_o, clear_o, clk_term_o},
          {5'b0, t_exp[110], t_exp[111], t_exp[112]});
      settle();
    end

    done = 1;
    finish_run();
  end
endmodule